// File: doc/BRIEF.md
# Maskable Event Interrupt Controller

This block gathers event conditions from the channels of a multi-channel serial card and turns them into one level-sensitive host interrupt. Firmware loads a mask with one bit per channel. A channel whose bit is set may raise the interrupt. A channel whose bit is clear still records its events, and the host fetches them with a poll read. A separate solicited-event input always raises the interrupt, whatever the mask holds. It is delivered only through the interrupt read and is never returned by a poll.

The host uses a read-then-acknowledge handshake. A read request says which path it wants: the interrupt path or the poll path. One cycle later the block returns an event block that holds an event code, a channel number and a payload. A later acknowledge clears the source named by that block. Pending state is kept for each source. Priority is fixed: a solicited event ranks above every channel, and among channels the lowest number wins.

Top module: `evt_irq_ctrl`

## Requirements
- R1: When `mask_we` is high at a clock edge, the mask takes the value of `mask_wdata`. Bit i set enables the interrupt for channel i, and bit i clear disables it.
- R2: `irq` is a registered level. After each edge it is high exactly when a solicited event is pending or some channel is both pending and enabled. It stays high until that condition is removed.
- R3: When every mask bit is clear and no solicited event is pending, `irq` stays low, whatever the channel events do.
- R4: A `sol_req` pulse sets the solicited-pending flag and captures `sol_info`, regardless of the mask, so `irq` is high after that edge. The solicited event is never returned by a poll read.
- R5: A pulse on `evt_req[i]` sets channel i pending whatever its mask bit. Channel i stays pending until an acknowledge clears it, and further pulses while it is pending merge into the one pending flag.
- R6: An interrupt read (`rd_req` with `rd_poll`=0) returns the solicited event if it is pending. Otherwise it returns the lowest-numbered channel that is both pending and enabled.
- R7: A poll read (`rd_req` with `rd_poll`=1) returns the lowest-numbered channel that is pending and whose mask bit is clear.
- R8: A read with nothing to return, and the block after reset, is all zeros, which is event code 0.
- R9: `rd_valid` pulses for exactly the one cycle after each edge with `rd_req`, and `rd_block` holds its value until the next read. Field layout of `rd_block`: bits [INFO_W-1:0] hold the payload (the captured `sol_info` for a solicited event, zero for a channel event). The next CH_W bits hold the channel number (zero for a solicited event). The top 4 bits hold the code: 1 for a channel event, 2 for a solicited event.
- R10: `ack` clears the source reported by the most recent read that returned a nonzero code and has not yet been acknowledged. An `ack` with no such source has no effect. A new event for that same source at the edge of the `ack` leaves it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_req | input | N_CH | One-cycle event pulse per channel |
| sol_req | input | 1 | One-cycle solicited-event pulse |
| sol_info | input | INFO_W | Payload captured with a solicited event |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | N_CH | New mask value |
| rd_req | input | 1 | Event block read request |
| rd_poll | input | 1 | Read path select: 0 interrupt, 1 poll |
| ack | input | 1 | Acknowledge of the last returned block |
| irq | output | 1 | Level-sensitive host interrupt |
| rd_valid | output | 1 | Event block valid pulse |
| rd_block | output | 4+CH_W+INFO_W | Event block: code, channel, payload |

## Verification
Every result is registered, so all of them are due exactly one clock after the edge that takes the stimulus. `irq` reflects event pulses, mask writes and acknowledges from that edge. `rd_valid` and `rd_block` reflect the read request and the pending state as they stood before that edge. The bench drives inputs on the falling edge, updates its reference model right after the rising edge, and compares all outputs on the next falling edge. Every comparison therefore lands in the first cycle the answer is due. Same-edge corner cases are scheduled on purpose: an event together with an acknowledge of its own source, and a solicited pulse while the mask is zero.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    EV_NONE  = 4'h0,
    EV_ASYNC = 4'h1,
    EV_SOL   = 4'h2
  } ev_code_e;
endpackage

// File: rtl/evt_irq_pick.sv
module evt_irq_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  // scan from the top so the lowest set bit is the last writer
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/evt_irq_fmt.sv
module evt_irq_fmt
  import evt_irq_pkg::*;
#(
  parameter int CH_W   = 3,
  parameter int INFO_W = 8,
  parameter int BLK_W  = CODE_W + CH_W + INFO_W
) (
  input  logic              poll,
  input  logic              sol_pend,
  input  logic [INFO_W-1:0] sol_info,
  input  logic              int_found,
  input  logic [CH_W-1:0]   int_idx,
  input  logic              poll_found,
  input  logic [CH_W-1:0]   poll_idx,
  output logic [BLK_W-1:0]  blk
);
  ev_code_e          code;
  logic [CH_W-1:0]   ch;
  logic [INFO_W-1:0] info;

  always_comb begin
    code = EV_NONE;
    ch   = '0;
    info = '0;
    if (!poll) begin
      if (sol_pend) begin
        code = EV_SOL;
        info = sol_info;
      end else if (int_found) begin
        code = EV_ASYNC;
        ch   = int_idx;
      end
    end else if (poll_found) begin
      code = EV_ASYNC;
      ch   = poll_idx;
    end
    blk = {code, ch, info};
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int INFO_W = 8,
  localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int BLK_W = CODE_W + CH_W + INFO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   evt_req,
  input  logic              sol_req,
  input  logic [INFO_W-1:0] sol_info,
  input  logic              mask_we,
  input  logic [N_CH-1:0]   mask_wdata,
  input  logic              rd_req,
  input  logic              rd_poll,
  input  logic              ack,
  output logic              irq,
  output logic              rd_valid,
  output logic [BLK_W-1:0]  rd_block
);
  // reset: asserted asynchronously, removed on a clock edge
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [N_CH-1:0]   mask_q, pend_q, pend_d, clr_vec;
  logic              sol_q, sol_d, sol_clr;
  logic [INFO_W-1:0] sol_info_q;
  logic              infl_vld_q, infl_vld_d, infl_sol_q, infl_sol_d;
  logic [CH_W-1:0]   infl_ch_q, infl_ch_d;
  logic              irq_d, rd_valid_q;
  logic [BLK_W-1:0]  rd_block_q, sel_blk;
  logic              int_found, poll_found;
  logic [CH_W-1:0]   int_idx, poll_idx;
  logic [CODE_W-1:0] sel_code;

  evt_irq_pick #(.N(N_CH), .IW(CH_W)) u_pick_int (
    .req(pend_q & mask_q), .found(int_found), .idx(int_idx));

  evt_irq_pick #(.N(N_CH), .IW(CH_W)) u_pick_poll (
    .req(pend_q & ~mask_q), .found(poll_found), .idx(poll_idx));

  evt_irq_fmt #(.CH_W(CH_W), .INFO_W(INFO_W), .BLK_W(BLK_W)) u_fmt (
    .poll(rd_poll), .sol_pend(sol_q), .sol_info(sol_info_q),
    .int_found(int_found), .int_idx(int_idx),
    .poll_found(poll_found), .poll_idx(poll_idx), .blk(sel_blk));

  assign sel_code = sel_blk[BLK_W-1 -: CODE_W];

  // next state
  always_comb begin
    clr_vec = '0;
    sol_clr = 1'b0;
    if (ack && infl_vld_q) begin
      if (infl_sol_q) sol_clr = 1'b1;
      else            clr_vec[infl_ch_q] = 1'b1;
    end
    // a fresh event at the same edge wins over the clear
    pend_d = (pend_q & ~clr_vec) | evt_req;
    sol_d  = (sol_q & ~sol_clr) | sol_req;
    irq_d  = sol_d | (|(pend_d & (mask_we ? mask_wdata : mask_q)));

    infl_vld_d = infl_vld_q;
    infl_sol_d = infl_sol_q;
    infl_ch_d  = infl_ch_q;
    if (rd_req) begin
      infl_vld_d = (sel_code != EV_NONE);
      infl_sol_d = (sel_code == EV_SOL);
      infl_ch_d  = sel_blk[INFO_W +: CH_W];
    end else if (ack) begin
      infl_vld_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q     <= '0;
      pend_q     <= '0;
      sol_q      <= 1'b0;
      sol_info_q <= '0;
      infl_vld_q <= 1'b0;
      infl_sol_q <= 1'b0;
      infl_ch_q  <= '0;
      irq        <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_block_q <= '0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      if (sol_req) sol_info_q <= sol_info;
      if (rd_req)  rd_block_q <= sel_blk;
      pend_q     <= pend_d;
      sol_q      <= sol_d;
      infl_vld_q <= infl_vld_d;
      infl_sol_q <= infl_sol_d;
      infl_ch_q  <= infl_ch_d;
      irq        <= irq_d;
      rd_valid_q <= rd_req;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_block = rd_block_q;
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int N_CH   = 8,
  parameter int INFO_W = 8,
  parameter int CH_W   = 3,
  parameter int BLK_W  = 4 + CH_W + INFO_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_CH-1:0]   evt_req,
  input logic              sol_req,
  input logic              mask_we,
  input logic              rd_req,
  input logic              ack,
  input logic              irq,
  input logic              rd_valid,
  input logic [BLK_W-1:0]  rd_block,
  input logic [N_CH-1:0]   mask_q,
  input logic [N_CH-1:0]   pend_q,
  input logic              sol_q,
  input logic              infl_vld_q,
  input logic              infl_sol_q,
  input logic [CH_W-1:0]   infl_ch_q
);
  a_r4_sol_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    sol_req |=> irq);

  a_r3_no_irq_when_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0 && !sol_q) |-> !irq);

  a_r2_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack && !mask_we) |=> irq);

  a_r5_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_req) |=> (|pend_q));

  a_r9_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  a_r8_empty_block_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_block[BLK_W-1 -: 4] == 4'h0) |-> (rd_block == '0));

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !rd_req && infl_vld_q && !infl_sol_q && !evt_req[infl_ch_q])
      |=> !pend_q[$past(infl_ch_q)]);
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
  .N_CH(N_CH), .INFO_W(INFO_W), .CH_W(CH_W), .BLK_W(BLK_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .evt_req(evt_req), .sol_req(sol_req),
  .mask_we(mask_we), .rd_req(rd_req), .ack(ack), .irq(irq),
  .rd_valid(rd_valid), .rd_block(rd_block), .mask_q(mask_q), .pend_q(pend_q),
  .sol_q(sol_q), .infl_vld_q(infl_vld_q), .infl_sol_q(infl_sol_q),
  .infl_ch_q(infl_ch_q)
);

// File: tb/evt_irq_ctrl_test.sv
`timescale 1ns/1ps
module evt_irq_ctrl_test;
  localparam int N_CH   = 8;
  localparam int INFO_W = 8;
  localparam int CH_W   = 3;
  localparam int BLK_W  = 4 + CH_W + INFO_W;

  logic clk = 1'b0;
  logic rst_n;
  logic [N_CH-1:0] evt_req, mask_wdata;
  logic sol_req, mask_we, rd_req, rd_poll, ack;
  logic [INFO_W-1:0] sol_info;
  logic irq, rd_valid;
  logic [BLK_W-1:0] rd_block;

  always #10 clk = ~clk;

  evt_irq_ctrl #(.N_CH(N_CH), .INFO_W(INFO_W)) uut (
    .clk(clk), .rst_n(rst_n), .evt_req(evt_req), .sol_req(sol_req),
    .sol_info(sol_info), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .rd_req(rd_req), .rd_poll(rd_poll), .ack(ack), .irq(irq),
    .rd_valid(rd_valid), .rd_block(rd_block));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic [N_CH-1:0] m_mask, m_pend;
  logic m_sol, m_ivld, m_isol;
  logic [INFO_W-1:0] m_info;
  logic [CH_W-1:0] m_ich;
  logic e_irq, e_valid, e_poll, last_ack, last_we;
  logic [BLK_W-1:0] e_blk;

  function automatic logic [BLK_W-1:0] model_block(input logic poll);
    logic [N_CH-1:0] v;
    v = poll ? (m_pend & ~m_mask) : (m_pend & m_mask);
    if (!poll && m_sol) return {4'h2, {CH_W{1'b0}}, m_info};
    for (int i = 0; i < N_CH; i++)
      if (v[i]) return {4'h1, CH_W'(i), {INFO_W{1'b0}}};
    return '0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [BLK_W-1:0] b;
    last_ack = 1'b0;
    last_we  = mask_we;
    e_valid  = rd_req;
    if (rd_req) begin
      b = model_block(rd_poll);
      e_blk  = b;
      e_poll = rd_poll;
    end
    if (ack && m_ivld) begin
      last_ack = 1'b1;
      if (m_isol) m_sol = 1'b0;
      else        m_pend[m_ich] = 1'b0;
    end
    if (rd_req) begin
      m_ivld = (b[BLK_W-1 -: 4] != 4'h0);
      m_isol = (b[BLK_W-1 -: 4] == 4'h2);
      m_ich  = b[INFO_W +: CH_W];
    end else if (ack) m_ivld = 1'b0;
    m_pend = m_pend | evt_req;
    if (sol_req) begin m_sol = 1'b1; m_info = sol_info; end
    if (mask_we) m_mask = mask_wdata;
    e_irq = m_sol | (|(m_pend & m_mask));
  endtask

  task automatic check_outputs();
    string t;
    if (m_mask == '0 && !m_sol) t = "R3";
    else if (last_ack)          t = "R10";
    else if (last_we)           t = "R1";
    else                        t = "R2";
    check(t, 32'(irq), 32'(e_irq));
    check("R9", 32'(rd_valid), 32'(e_valid));
    if (e_blk[BLK_W-1 -: 4] == 4'h0)      t = "R8";
    else if (e_poll)                      t = "R7/R5";
    else if (e_blk[BLK_W-1 -: 4] == 4'h2) t = "R4";
    else                                  t = "R6";
    check(t, 32'(rd_block), 32'(e_blk));
  endtask

  task automatic idle();
    evt_req = '0; sol_req = 1'b0; sol_info = '0; mask_we = 1'b0;
    mask_wdata = '0; rd_req = 1'b0; rd_poll = 1'b0; ack = 1'b0;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_outputs();
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    idle();
    rst_n = 1'b0;
    m_mask = '0; m_pend = '0; m_sol = 0; m_ivld = 0; m_isol = 0;
    m_info = '0; m_ich = '0; e_irq = 0; e_valid = 0; e_poll = 0;
    e_blk = '0; last_ack = 0; last_we = 0;
    repeat (3) @(negedge clk);
    check("R8 reset block", 32'(rd_block), 32'h0);
    check("R2 reset irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3/R5/R7: disabled channel pends without irq, poll finds it
    evt_req = 8'h08; cyc();
    rd_req = 1; rd_poll = 1; cyc();
    ack = 1; cyc();
    rd_req = 1; rd_poll = 1; cyc();           // R8 empty poll
    // R1: enable channels 2,3; R6 lowest enabled wins
    mask_we = 1; mask_wdata = 8'h0C; cyc();
    evt_req = 8'h28; cyc();
    rd_req = 1; cyc();
    rd_req = 1; rd_poll = 1; cyc();           // poll returns 5
    // R4: solicited ranks first, poll skips it
    sol_req = 1; sol_info = 8'hA5; cyc();
    rd_req = 1; cyc();
    rd_req = 1; rd_poll = 1; cyc();
    rd_req = 1; cyc();
    ack = 1; cyc();                           // R10 clears solicited
    // R10: re-event at ack edge keeps channel 3 pending
    rd_req = 1; cyc();
    ack = 1; evt_req = 8'h08; cyc();
    ack = 1; cyc();                           // no source: no effect
    // R4 with mask zero
    mask_we = 1; mask_wdata = 8'h00; cyc();
    sol_req = 1; sol_info = 8'h3C; cyc();
    rd_req = 1; cyc();
    ack = 1; cyc();

    for (int k = 0; k < 4000; k++) begin
      for (int c = 0; c < N_CH; c++) evt_req[c] = ($urandom % 10) == 0;
      sol_req  = ($urandom % 20) == 0;
      sol_info = INFO_W'($urandom);
      mask_we  = ($urandom % 12) == 0;
      mask_wdata = ($urandom % 4 == 0) ? '0 : N_CH'($urandom);
      rd_req   = ($urandom % 3) == 0;
      rd_poll  = $urandom % 2;
      ack      = !rd_req && (($urandom % 2) == 0);
      cyc();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule